// File: doc/BRIEF.md
# Supply Reset Guard with Watchdog Fail-Safe Latch

This block drives the processor reset and halt lines of a module and keeps a sticky fail-safe flag. It watches three inputs: a logic-rail-good level, an external reset request and a low-true watchdog output. While the rail is bad, both lines are pulled low at once, with no clock needed. Once the rail is good again, the lines stay pulled low for a stretch sized in milliseconds from a clock-frequency parameter. An external request pulls them low for at least a minimum number of cycles, or for as long as it is held if that is longer.

The two lines are shared open-drain nets. The block drives each one through a pull enable and reads the net back through a sense input. After releasing its pulls, it waits until both nets actually read high before it enters normal running.

A low watchdog level sets the fail-safe flag. While the flag is set, the link transmitter enable stays off. The processor cannot clear the flag. It is cleared only at the end of a reset stretch or an external hold, so a watchdog trip that happens during a reset is cleared when that reset ends.

The controller has four states:
- `ST_STRETCH`: the power-up stretch. The block enters it on rail loss.
- `ST_EXT_HOLD`: the external hold.
- `ST_RELEASE`: the pulls are off and the block waits for both nets to read high.
- `ST_RUN`: normal running.

The transitions are:
- stretch done: `ST_STRETCH` to `ST_RELEASE`.
- hold done: `ST_EXT_HOLD` to `ST_RELEASE`.
- lines high: `ST_RELEASE` to `ST_RUN`.
- external request: `ST_RUN` or `ST_RELEASE` to `ST_EXT_HOLD`.
- rail loss: any state to `ST_STRETCH`, asynchronously.

The external request, the watchdog level and the AND of the two sense inputs each pass through SYNC_STAGES flops (default 2) before the controller sees them. The default rail-loss clocks per millisecond and the stretch length are parameters: CLK_HZ (default 200 MHz) and STRETCH_MS (default 130). The stretch length in cycles is STRETCH_CYC = (CLK_HZ/1000)*STRETCH_MS. The minimum external hold is EXT_MIN_CYC cycles (default 24).

Top module: `supply_reset_guard`

## Requirements
- R1: While rail_good is 0, rst_pull and halt_pull are 1, failsafe is 1 and tx_enable is 0. These values appear as soon as rail_good falls, without a clock edge.
- R2: After rail_good rises, the pulls stay 1 until the (SYNC_STAGES+STRETCH_CYC)th rising clock edge, and fall at that edge.
- R3: If rail_good drops during the stretch, the stretch restarts in full from the next rise.
- R4: An ext_reset_req level of 1, seen in ST_RUN or ST_RELEASE, sets the pulls at the (SYNC_STAGES+1)th edge after it rises. They stay 1 for EXT_MIN_CYC cycles, or for as many cycles as the request was held if that is longer.
- R5: An external request that arrives during the power-up stretch has no effect; the stretch length is unchanged.
- R6: After the pulls release, tx_enable stays 0 until both rst_line_sense_n and halt_line_sense_n read 1 through the synchronizer. A net held low by another driver keeps the block out of ST_RUN.
- R7: wdog_n at 0 sets failsafe SYNC_STAGES+1 edges later, in any state. failsafe stays 1 after wdog_n returns to 1.
- R8: failsafe falls only at the edge where a stretch or an external hold ends. A watchdog trip during the hold is cleared by that end.
- R9: tx_enable is 1 only in ST_RUN with failsafe 0. tx_enable falls at the same edge where failsafe rises.
- R10: halt_pull always equals rst_pull.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rail_good | input | 1 | Logic rail within range (1); also the asynchronous block reset |
| ext_reset_req | input | 1 | External reset request, active high |
| wdog_n | input | 1 | Watchdog output, low-true trip |
| rst_line_sense_n | input | 1 | Read-back of the shared reset net |
| halt_line_sense_n | input | 1 | Read-back of the shared halt net |
| rst_pull | output | 1 | Enable that pulls the reset net low |
| halt_pull | output | 1 | Enable that pulls the halt net low |
| failsafe | output | 1 | Sticky fail-safe flag |
| tx_enable | output | 1 | Link transmitter permitted |

## Verification
A wrong internal state shows up within one cycle as a mismatch in rst_pull or tx_enable. For example, a counter that leaves the stretch early makes the pulls fall an exact number of cycles too soon. A flag that clears too easily lets tx_enable rise before a reset source has acted. Every output is compared each cycle against an independent cycle model, so such errors are caught at the first divergent edge. Directed measurements also check the stretch length, the restart on rail loss, the minimum and the held external pulse, and the line-release wait.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

    typedef enum logic [1:0] {
        ST_STRETCH  = 2'd0,
        ST_EXT_HOLD = 2'd1,
        ST_RELEASE  = 2'd2,
        ST_RUN      = 2'd3
    } guard_state_e;

endpackage

// File: rtl/rsg_reset_sync.sv
module rsg_reset_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= {chain[STAGES-2:0], 1'b1};
    end

    assign rst_n = chain[STAGES-1];
endmodule

// File: rtl/rsg_bit_sync.sv
module rsg_bit_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rsg_hold_timer.sv
module rsg_hold_timer #(
    parameter int MAX_COUNT = 255,
    parameter int W         = $clog2(MAX_COUNT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         advance,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] LIMIT = W'(MAX_COUNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           count <= '0;
        else if (clear)                       count <= '0;
        else if (advance && (count != LIMIT)) count <= count + 1'b1;
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LIMIT);
endmodule

// File: rtl/rsg_fail_latch.sv
module rsg_fail_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q,
    output logic q_next
);
    always_comb begin
        if (clr)      q_next = 1'b0;
        else if (set) q_next = 1'b1;
        else          q_next = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b1;
        else        q <= q_next;
    end

    // R7
    trip_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !clr) |=> q);

    // R8
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q) |-> $past(clr));
endmodule

// File: rtl/supply_reset_guard.sv
module supply_reset_guard
    import rsg_pkg::*;
#(
    parameter int CLK_HZ      = 200_000_000,
    parameter int STRETCH_MS  = 130,
    parameter int EXT_MIN_CYC = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rail_good,
    input  logic ext_reset_req,
    input  logic wdog_n,
    input  logic rst_line_sense_n,
    input  logic halt_line_sense_n,
    output logic rst_pull,
    output logic halt_pull,
    output logic failsafe,
    output logic tx_enable
);
    localparam int STRETCH_CYC = (CLK_HZ / 1000) * STRETCH_MS;
    localparam int MAX_CNT     = (STRETCH_CYC > EXT_MIN_CYC) ? STRETCH_CYC : EXT_MIN_CYC;
    localparam int CNT_W       = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] STRETCH_LAST = CNT_W'(STRETCH_CYC - 1);
    localparam logic [CNT_W-1:0] EXT_LAST     = CNT_W'(EXT_MIN_CYC - 1);

    logic rst_n;
    logic ext_s, wd_s, lines_hi;
    logic [CNT_W-1:0] cnt;
    logic timer_clear, timer_adv, fail_clr;
    logic fail_q, fail_next;
    logic rst_q, halt_q, tx_q;
    guard_state_e state_q, state_d;

    rsg_reset_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .clk(clk), .arst_n(rail_good), .rst_n(rst_n));

    rsg_bit_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .d(ext_reset_req), .q(ext_s));

    rsg_bit_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_wd_sync (
        .clk(clk), .rst_n(rst_n), .d(wdog_n), .q(wd_s));

    rsg_bit_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_line_sync (
        .clk(clk), .rst_n(rst_n), .d(rst_line_sense_n & halt_line_sense_n), .q(lines_hi));

    rsg_hold_timer #(.MAX_COUNT(MAX_CNT), .W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(timer_clear), .advance(timer_adv), .count(cnt));

    rsg_fail_latch u_fail (
        .clk(clk), .rst_n(rst_n), .set(!wd_s), .clr(fail_clr),
        .q(fail_q), .q_next(fail_next));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STRETCH;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d     = state_q;
        timer_clear = 1'b0;
        timer_adv   = 1'b0;
        fail_clr    = 1'b0;
        unique case (state_q)
            ST_STRETCH: begin
                if (cnt == STRETCH_LAST) begin
                    state_d     = ST_RELEASE;
                    timer_clear = 1'b1;
                    fail_clr    = 1'b1;
                end else begin
                    timer_adv = 1'b1;
                end
            end
            ST_EXT_HOLD: begin
                if ((cnt >= EXT_LAST) && !ext_s) begin
                    state_d     = ST_RELEASE;
                    timer_clear = 1'b1;
                    fail_clr    = 1'b1;
                end else begin
                    timer_adv = (cnt < EXT_LAST);
                end
            end
            ST_RELEASE: begin
                if (ext_s) begin
                    state_d     = ST_EXT_HOLD;
                    timer_clear = 1'b1;
                end else if (lines_hi) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (ext_s) begin
                    state_d     = ST_EXT_HOLD;
                    timer_clear = 1'b1;
                end
            end
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_q  <= 1'b1;
            halt_q <= 1'b1;
            tx_q   <= 1'b0;
        end else begin
            rst_q  <= (state_d == ST_STRETCH) || (state_d == ST_EXT_HOLD);
            halt_q <= (state_d == ST_STRETCH) || (state_d == ST_EXT_HOLD);
            tx_q   <= (state_d == ST_RUN) && !fail_next;
        end
    end

    assign rst_pull  = rst_q;
    assign halt_pull = halt_q;
    assign failsafe  = fail_q;
    assign tx_enable = tx_q;

    // R2
    stretch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELEASE && $past(state_q) == ST_STRETCH) |-> ($past(cnt) == STRETCH_LAST));

    // R4
    ext_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELEASE && $past(state_q) == ST_EXT_HOLD) |-> ($past(cnt) >= EXT_LAST));

    // R6
    run_needs_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_enable) |-> $past(lines_hi));

    // R9
    tx_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_enable |-> (!failsafe && !rst_pull));
endmodule

// File: tb/supply_reset_guard_test.sv
`timescale 1ns/1ps
module supply_reset_guard_test;
    localparam int S  = 130;
    localparam int E  = 24;

    logic clk = 1'b0;
    logic rail_good, ext_reset_req, wdog_n;
    logic other_rst, other_halt;
    logic rst_pull, halt_pull, failsafe, tx_enable;
    wire  rst_line_n  = !(rst_pull | other_rst);
    wire  halt_line_n = !(halt_pull | other_halt);

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    supply_reset_guard #(.CLK_HZ(1000), .STRETCH_MS(130), .EXT_MIN_CYC(E), .SYNC_STAGES(2)) uut (
        .clk(clk), .rail_good(rail_good), .ext_reset_req(ext_reset_req), .wdog_n(wdog_n),
        .rst_line_sense_n(rst_line_n), .halt_line_sense_n(halt_line_n),
        .rst_pull(rst_pull), .halt_pull(halt_pull), .failsafe(failsafe), .tx_enable(tx_enable));

    // independent cycle model of the requirements
    logic [1:0] m_rs, m_es, m_ws, m_ls;
    logic m_run;
    int   m_st, m_cnt;
    logic m_fail, m_pull, m_tx;
    int   n_st, n_cnt;
    logic n_clr, n_fail;

    always @(posedge clk or negedge rail_good)
        if (!rail_good) m_rs <= 2'b00;
        else            m_rs <= {m_rs[0], 1'b1};
    assign m_run = m_rs[1];

    always @(posedge clk or negedge m_run) begin
        if (!m_run) begin
            m_es <= 2'b00; m_ws <= 2'b11; m_ls <= 2'b00;
            m_st <= 0; m_cnt <= 0; m_fail <= 1'b1; m_pull <= 1'b1; m_tx <= 1'b0;
        end else begin
            n_st = m_st; n_cnt = m_cnt; n_clr = 1'b0;
            case (m_st)
                0: if (m_cnt == S-1) begin n_st = 2; n_cnt = 0; n_clr = 1'b1; end
                   else n_cnt = m_cnt + 1;
                1: if (m_cnt >= E-1 && !m_es[1]) begin n_st = 2; n_cnt = 0; n_clr = 1'b1; end
                   else if (m_cnt < E-1) n_cnt = m_cnt + 1;
                2: if (m_es[1]) begin n_st = 1; n_cnt = 0; end
                   else if (m_ls[1]) n_st = 3;
                default: if (m_es[1]) begin n_st = 1; n_cnt = 0; end
            endcase
            n_fail = n_clr ? 1'b0 : (!m_ws[1] ? 1'b1 : m_fail);
            m_st <= n_st; m_cnt <= n_cnt; m_fail <= n_fail;
            m_pull <= (n_st == 0) || (n_st == 1);
            m_tx <= (n_st == 3) && !n_fail;
            m_es <= {m_es[0], ext_reset_req};
            m_ws <= {m_ws[0], wdog_n};
            m_ls <= {m_ls[0], rst_line_n & halt_line_n};
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) if (!done) begin
        check(rst_pull == m_pull,
              !rail_good ? "R1 rst_pull" : (m_st == 0 ? "R2 rst_pull" : (m_st == 1 ? "R4 rst_pull" : "R6 rst_pull")),
              rst_pull, m_pull);
        check(halt_pull == rst_pull, "R10 halt_pull", halt_pull, rst_pull);
        check(failsafe == m_fail, m_fail ? "R7 failsafe" : "R8 failsafe", failsafe, m_fail);
        check(tx_enable == m_tx, "R9 tx_enable", tx_enable, m_tx);
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic count_high(output int n);
        n = 0;
        @(negedge clk);
        for (int g = 0; g < 8 && !rst_pull; g++) @(negedge clk);
        while (rst_pull && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        void'($urandom(32'd4711));
        rail_good = 0; ext_reset_req = 0; wdog_n = 1; other_rst = 0; other_halt = 0;
        step(4);
        // R1 reset state
        check(rst_pull && halt_pull && failsafe && !tx_enable, "R1 reset state", {rst_pull, failsafe, tx_enable}, 3'b110);

        // R2 stretch length
        rail_good = 1;
        count_high(n);
        check(n == S + 1, "R2 stretch length", n, S + 1);
        step(6);
        check(tx_enable && !failsafe, "R9 running", tx_enable, 1);

        // R7 watchdog trip is sticky
        wdog_n = 0; step(1); wdog_n = 1;
        step(6);
        check(failsafe == 1, "R7 sticky trip", failsafe, 1);
        check(tx_enable == 0, "R9 tx off on trip", tx_enable, 0);

        // R4 minimum external pulse, R8 clears flag
        ext_reset_req = 1; step(1); ext_reset_req = 0;
        count_high(n);
        check(n == E, "R4 minimum pulse", n, E);
        step(6);
        check(failsafe == 0, "R8 cleared by hold", failsafe, 0);
        check(tx_enable == 1, "R9 tx back", tx_enable, 1);

        // R4 held request lengthens the pulse
        ext_reset_req = 1;
        fork
            begin step(40); ext_reset_req = 0; end
            count_high(n);
        join
        check(n == 40, "R4 held pulse", n, 40);
        step(6);

        // R8 watchdog trip during the hold is wiped at its end
        ext_reset_req = 1; step(1); ext_reset_req = 0;
        step(8); wdog_n = 0; step(1); wdog_n = 1;
        step(40);
        check(failsafe == 0, "R8 trip during hold", failsafe, 0);

        // R6 foreign driver holds the net low
        other_rst = 1;
        ext_reset_req = 1; step(1); ext_reset_req = 0;
        step(60);
        check(rst_pull == 0 && tx_enable == 0, "R6 wait for lines", tx_enable, 0);
        other_rst = 0;
        step(6);
        check(tx_enable == 1, "R6 run after release", tx_enable, 1);

        // R1 asynchronous rail loss, R3 restart of the stretch
        rail_good = 0; #0.5;
        check(rst_pull && failsafe && !tx_enable, "R1 async drop", rst_pull, 1);
        step(2); rail_good = 1;
        step(50); rail_good = 0; step(3); rail_good = 1;
        count_high(n);
        check(n == S + 1, "R3 restarted stretch", n, S + 1);
        step(6);

        // R5 external request during the stretch is ignored
        rail_good = 0; step(2); rail_good = 1;
        fork
            begin step(20); ext_reset_req = 1; step(3); ext_reset_req = 0; end
            count_high(n);
        join
        check(n == S + 1, "R5 stretch unchanged", n, S + 1);
        step(6);

        // random mix, checked every cycle against the model
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = int'($urandom % 1000);
            if (r < 2)        rail_good = 0;
            else if (r < 40)  rail_good = 1;
            if (r >= 100 && r < 115) ext_reset_req = 1;
            else if (r >= 115 && r < 300) ext_reset_req = 0;
            wdog_n = !(r >= 300 && r < 310);
            if (r >= 400 && r < 406) other_rst = ~other_rst;
            if (r >= 500 && r < 506) other_halt = ~other_halt;
            step(1);
        end
        rail_good = 1; ext_reset_req = 0; wdog_n = 1; other_rst = 0; other_halt = 0;
        step(S + 20);
        check(tx_enable == 1 && failsafe == 0, "R9 final run", tx_enable, 1);
        finish_run();
    end
endmodule